// File: doc/BRIEF.md
# Buffered Two-Register PWM Timer

This block makes a pulse-width-modulated waveform from a 16-bit up-counter. A prescaler divides the clock by a power of two, and the divided tick advances the counter. The counter runs from 0 up to a programmable period limit and then wraps to 0. That wrap is the overflow. The output is high while the count is below the active width value and low from there until the next overflow.

Setting the pairing bit joins two width registers into one buffered source that drives a single output. A width written into the idle register takes over cleanly at the next overflow. At every overflow, the register written most recently becomes the active one. A write to the register that is already active takes effect within the current period, as with an unbuffered update. While the pair is joined, a flag tells the rest of the chip that the second channel's pin is free for other use.

Software reaches the block through a small word-wide register bus. Writes take effect on the clock edge. Reads are combinational.

Top module: `pwm_pair_timer`

## Requirements
- R1: After reset the period register reads 16'hFFFF, both width registers read 0, the control word reads 0, `pwm_o` is low and `pin1_free_o` is low.
- R2: The control field at bits [5:3] selects the divider as 2^sel, and the codes 6 and 7 both divide by 64. The counter advances once per divided tick.
- R3: The counter counts 0, 1, ... up to the period register value. On the next tick it returns to 0, and that tick is the overflow.
- R4: While paired, `pwm_o` is high exactly when the count is below the active width. A width of 0 gives a constant low output, and a width above the period value gives a constant high output.
- R5: Control bit 2 pairs the registers. `pin1_free_o` follows it. A write that sets the bit while it is clear makes register 0 (address 2) the active source.
- R6: A write to the idle width register leaves the output and the active source unchanged until the next overflow. At that overflow the written register becomes active.
- R7: At each overflow the register written last becomes active. If register 1 and then register 0 are written inside one period, register 0 stays active.
- R8: A write to the active width register changes the output in the next cycle, without waiting for an overflow.
- R9: While control bit 0 (stop) is set, the counter and the prescaler hold their values and no overflow occurs.
- R10: Writing 1 to control bit 1 clears the counter and the prescaler at that edge and suppresses any overflow in that cycle. The bit always reads back 0.
- R11: Control bit 8 reads the index of the active register. It changes on the same edge as the overflow that switches the source.
- R12: While unpaired, `pwm_o` stays low and writes to the width registers do not change the active index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register select: 0 control, 1 period, 2 width 0, 3 width 1 |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for the selected register |
| pwm_o | output | 1 | PWM output |
| pin1_free_o | output | 1 | High while paired: the second pin is released |

## Verification
A behavioural model runs next to the design and is compared on every clock, while several stimulus patterns run. Idle-register writes are separated from active-register writes to show buffered versus immediate updates. A double write inside one period shows that the last write wins. Width values of 0 and above the period check the constant outputs. Divider codes 0, 2 and 7 check the prescaler's 64 saturation. Writes made while the counter is stopped pin the status bit and the output to hand-computed values. A clear issued mid-count and the unpaired state show that the counter resets and that the active index is left alone.

// File: rtl/ptm_pkg.sv
package ptm_pkg;
  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_PER  = 2'd1,
    A_CMP0 = 2'd2,
    A_CMP1 = 2'd3
  } ptm_addr_e;

  localparam int unsigned B_STOP  = 0;
  localparam int unsigned B_CLR   = 1;
  localparam int unsigned B_LINK  = 2;
  localparam int unsigned B_SEL   = 3;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned B_ACT   = 8;
endpackage

// File: rtl/ptm_prescaler.sv
module ptm_prescaler #(
  parameter int unsigned PW = 6
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      run_i,
  input  logic                      clr_i,
  input  logic [ptm_pkg::SEL_W-1:0] sel_i,
  output logic                      tick_o
);
  localparam logic [ptm_pkg::SEL_W-1:0] MAX_SEL = ptm_pkg::SEL_W'(PW);

  logic [PW-1:0]             psc_q;
  logic [PW-1:0]             mask;
  logic [ptm_pkg::SEL_W-1:0] sel_eff;

  assign sel_eff = (sel_i > MAX_SEL) ? MAX_SEL : sel_i;

  always_comb begin
    for (int i = 0; i < int'(PW); i++) mask[i] = (ptm_pkg::SEL_W'(i) < sel_eff);
  end

  assign tick_o = run_i && ((psc_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    psc_q <= '0;
    else if (clr_i) psc_q <= '0;
    else if (run_i) psc_q <= psc_q + 1'b1;
  end

  assert_psc_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> $stable(psc_q));
  assert_psc_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (psc_q == '0));
endmodule

// File: rtl/ptm_counter.sv
module ptm_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         clr_i,
  input  logic [W-1:0] per_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  logic [W-1:0] cnt_q;
  logic         at_top;

  assign at_top = (cnt_q == per_i);
  assign ovf_o  = tick_i && !clr_i && at_top;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= at_top ? '0 : cnt_q + 1'b1;
  end

  assert_wrap_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> (cnt_q == '0));
  assert_cnt_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(cnt_q));
  assert_cnt_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/ptm_buf_sel.sv
module ptm_buf_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic link_i,
  input  logic link_rise_i,
  input  logic wr_cmp0_i,
  input  logic wr_cmp1_i,
  input  logic ovf_i,
  output logic act_o
);
  logic act_q, last_q, last_d;

  always_comb begin
    last_d = last_q;
    if (link_i && wr_cmp0_i) last_d = 1'b0;
    if (link_i && wr_cmp1_i) last_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      last_q <= 1'b0;
    end else if (link_rise_i) begin
      act_q  <= 1'b0;
      last_q <= 1'b0;
    end else begin
      last_q <= last_d;
      if (ovf_i && link_i) act_q <= last_d;
    end
  end

  assign act_o = act_q;

  // the source moves only on an overflow or a fresh pairing
  assert_act_only_at_ovf_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovf_i && !link_rise_i) |=> $stable(act_q));
  assert_link_picks_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_rise_i |=> (act_q == 1'b0));
  assert_unlinked_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!link_i && !link_rise_i) |=> $stable(act_q));
endmodule

// File: rtl/pwm_pair_timer.sv
module pwm_pair_timer #(
  parameter int unsigned CW = 16,
  parameter int unsigned PW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_we_i,
  input  logic [1:0]    bus_addr_i,
  input  logic [CW-1:0] bus_wdata_i,
  output logic [CW-1:0] bus_rdata_o,
  output logic          pwm_o,
  output logic          pin1_free_o
);
  import ptm_pkg::*;

  localparam int unsigned NCH = 2;

  logic                stop_q, link_q;
  logic [SEL_W-1:0]    sel_q;
  logic [CW-1:0]       per_q;
  logic [CW-1:0]       cmp_q [NCH];
  logic [NCH-1:0]      cmp_wr;
  logic                ctrl_wr, clr_wr, link_rise;
  logic                tick, ovf, act;
  logic [CW-1:0]       cnt, cmp_act;

  assign ctrl_wr   = bus_we_i && (bus_addr_i == A_CTRL);
  assign clr_wr    = ctrl_wr && bus_wdata_i[B_CLR];
  assign link_rise = ctrl_wr && bus_wdata_i[B_LINK] && !link_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_q <= 1'b0;
      link_q <= 1'b0;
      sel_q  <= '0;
      per_q  <= '1;
    end else begin
      if (ctrl_wr) begin
        stop_q <= bus_wdata_i[B_STOP];
        link_q <= bus_wdata_i[B_LINK];
        sel_q  <= bus_wdata_i[B_SEL +: SEL_W];
      end
      if (bus_we_i && bus_addr_i == A_PER) per_q <= bus_wdata_i;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_cmp
    assign cmp_wr[g] = bus_we_i && (bus_addr_i == 2'(int'(A_CMP0) + g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        cmp_q[g] <= '0;
      else if (cmp_wr[g]) cmp_q[g] <= bus_wdata_i;
    end
  end

  ptm_prescaler #(.PW(PW)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (!stop_q),
    .clr_i  (clr_wr),
    .sel_i  (sel_q),
    .tick_o (tick)
  );

  ptm_counter #(.W(CW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .clr_i  (clr_wr),
    .per_i  (per_q),
    .cnt_o  (cnt),
    .ovf_o  (ovf)
  );

  ptm_buf_sel u_sel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .link_i      (link_q),
    .link_rise_i (link_rise),
    .wr_cmp0_i   (cmp_wr[0]),
    .wr_cmp1_i   (cmp_wr[1]),
    .ovf_i       (ovf),
    .act_o       (act)
  );

  assign cmp_act     = cmp_q[act];
  assign pwm_o       = link_q && (cnt < cmp_act);
  assign pin1_free_o = link_q;

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      A_CTRL: begin
        bus_rdata_o[B_STOP]            = stop_q;
        bus_rdata_o[B_LINK]            = link_q;
        bus_rdata_o[B_SEL +: SEL_W]    = sel_q;
        bus_rdata_o[B_ACT]             = act;
      end
      A_PER:   bus_rdata_o = per_q;
      A_CMP0:  bus_rdata_o = cmp_q[0];
      default: bus_rdata_o = cmp_q[1];
    endcase
  end

  assert_stopped_no_ovf_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_q |-> !ovf);
  assert_unpaired_low_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_q |-> !pwm_o);
endmodule

// File: tb/sim_pwm_pair_timer.sv
module sim_pwm_pair_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        pwm, free;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  pwm_pair_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pwm_o(pwm), .pin1_free_o(free)
  );

  // behavioural reference
  int m_psc, m_cnt, m_per, m_stop, m_link, m_sel, m_act, m_last;
  int m_cmp [2];

  function automatic int m_div();
    int s = (m_sel > 6) ? 6 : m_sel;
    return 1 << s;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_psc = 0; m_cnt = 0; m_per = 65535; m_stop = 0; m_link = 0;
      m_sel = 0; m_act = 0; m_last = 0; m_cmp[0] = 0; m_cmp[1] = 0;
    end else begin
      int d, nl;
      bit tk, clrw, ov;
      d    = m_div();
      tk   = !m_stop && ((m_psc % d) == d - 1);
      clrw = we && addr == 0 && wdata[1];
      ov   = tk && !clrw && (m_cnt == m_per);
      if (clrw) m_psc = 0; else if (!m_stop) m_psc = (m_psc + 1) % 64;
      if (clrw) m_cnt = 0;
      else if (tk) m_cnt = (m_cnt == m_per) ? 0 : (m_cnt + 1) % 65536;
      nl = m_last;
      if (m_link && we && addr == 2) nl = 0;
      if (m_link && we && addr == 3) nl = 1;
      if (ov && m_link) m_act = nl;
      m_last = nl;
      if (we && addr == 0 && wdata[2] && m_link == 0) begin m_act = 0; m_last = 0; end
      if (we) case (addr)
        2'd0: begin m_stop = wdata[0]; m_link = wdata[2]; m_sel = wdata[5:3]; end
        2'd1: m_per = wdata;
        2'd2: m_cmp[0] = wdata;
        default: m_cmp[1] = wdata;
      endcase
    end
  end

  function automatic int m_read(int a);
    case (a)
      0: return (m_act << 8) | (m_sel << 3) | (m_link << 2) | m_stop;
      1: return m_per;
      2: return m_cmp[0];
      default: return m_cmp[1];
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act_v, int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act_v, exp_v, $time);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) if (rst_n) begin
    int ep;
    ep = (m_link != 0 && m_cnt < m_cmp[m_act]) ? 1 : 0;
    chk(pwm == ep[0], "R4 pwm vs model", pwm, ep);
    chk(free == m_link[0], "R5 pin released", free, m_link);
    chk(rdata == 16'(m_read(addr)), "R11 readback vs model", rdata, m_read(addr));
  end

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(posedge clk); #1;
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      we = 1'b0; addr = 2'(i);
    end
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] v);
    @(posedge clk); #1;
    we = 1'b0; addr = a;
    @(negedge clk);
    v = rdata;
  endtask

  localparam logic [15:0] LNK = 16'h0004;
  localparam logic [15:0] STP = 16'h0001;

  initial begin
    logic [15:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(pwm == 1'b0, "R1 pwm low", pwm, 0);
    chk(free == 1'b0, "R1 pin free low", free, 0);
    rd(2'd1, v); chk(v == 16'hFFFF, "R1 period reset", v, 16'hFFFF);
    rd(2'd2, v); chk(v == 16'h0,    "R1 width0 reset", v, 0);
    rd(2'd0, v); chk(v == 16'h0,    "R1 ctrl reset", v, 0);

    // R12 unpaired: width writes do not move the source
    wr(2'd1, 16'd9);
    wr(2'd3, 16'd5);
    idle(25);
    rd(2'd0, v); chk(v[8] == 1'b0, "R12 unpaired act", v[8], 0);
    chk(pwm == 1'b0, "R12 unpaired pwm", pwm, 0);

    // R3/R4/R5 paired, /1
    wr(2'd2, 16'd4);
    wr(2'd3, 16'd7);
    wr(2'd0, LNK);
    idle(30);

    // R6 idle write frozen while stopped
    wr(2'd0, LNK | STP);
    rd(2'd0, v); chk(v[8] == 1'b0, "R6 act before write", v[8], 0);
    wr(2'd3, 16'd2);
    rd(2'd0, v); chk(v[8] == 1'b0, "R6 idle write buffered", v[8], 0);
    wr(2'd0, LNK);
    idle(25);
    rd(2'd0, v); chk(v[8] == 1'b1, "R6 R11 switched at overflow", v[8], 1);

    // R8 immediate write to active (register 1), counter frozen
    wr(2'd0, LNK | STP);
    wr(2'd3, 16'd0);
    @(negedge clk); chk(pwm == 1'b0, "R8 active write to 0", pwm, 0);
    wr(2'd3, 16'd20);
    @(negedge clk); chk(pwm == 1'b1, "R8 active write high", pwm, 1);
    wr(2'd0, LNK);
    idle(25);

    // R7 two writes in one period: last wins
    wr(2'd3, 16'd3);
    wr(2'd2, 16'd5);
    idle(25);
    rd(2'd0, v); chk(v[8] == 1'b0, "R7 last write wins", v[8], 0);

    // R4 constant outputs
    wr(2'd2, 16'd0); idle(25);
    wr(2'd2, 16'd12); idle(25);

    // R2 divider codes
    wr(2'd0, LNK | (16'd2 << 3)); idle(90);
    wr(2'd2, 16'd6);
    wr(2'd0, LNK | (16'd7 << 3)); idle(1400);

    // R10 clear mid-count, reads 0
    wr(2'd0, LNK | 16'h0002);
    rd(2'd0, v); chk(v[1] == 1'b0, "R10 clear reads 0", v[1], 0);
    wr(2'd0, LNK); idle(30);
    wr(2'd0, LNK | 16'h0002); idle(5);

    // R9 stop
    wr(2'd0, LNK | STP); idle(40);
    wr(2'd0, LNK);
    wr(2'd1, 16'd0); idle(10);
    wr(2'd1, 16'd6); idle(30);

    // unpair: output low, pin returned
    wr(2'd0, 16'h0); idle(10);
    chk(pwm == 1'b0 && free == 1'b0, "R12 after unpair", {pwm, free}, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule